// File: doc/BRIEF.md
# Scalar-Only Operation Detector

This block sits in the decode stage of a core whose registers can each be marked as the start of a vector. It keeps one flag per architectural register that says whether the register is vectorised. Each decoded instruction looks up its first source, second source and destination in the same cycle. If every used operand is scalar, the instruction is flagged for the bypass path and goes straight to the ALU or instruction FIFO. If any used operand is vectorised, the instruction is steered into the vectorisation path. In a minimal build, the same condition raises a trap for software emulation instead.

Software never writes the flags directly. They follow the per-register vector configuration writes: a configured length of two or more marks the register as vectorised. A configuration write and a lookup of the same register in the same cycle already see the new flag. The lookup result is registered and appears one clock after the lookup.

Top module: `scalar_op_detect`

## Requirements
- R1: On reset (rst_ni low) every flag clears and all three outputs are 0. After reset, every register looks up as scalar until it is configured.
- R2: A configuration write with cfg_len_i >= 2 marks register cfg_idx_i vectorised. A write with cfg_len_i of 0 or 1 marks it scalar.
- R3: A lookup with lk_valid_i high whose used operands are all scalar gives bypass_o = 1 on the next cycle.
- R4: When trap_mode_i = 0, a lookup in which any used operand is vectorised gives vector_o = 1 and trap_o = 0 on the next cycle.
- R5: When trap_mode_i = 1, the same condition gives trap_o = 1 and vector_o = 0 on the next cycle.
- R6: An operand whose use bit is 0 counts as scalar, whatever flag its index holds.
- R7: A configuration write and a lookup of the same index in the same cycle use the newly written flag.
- R8: Register index 0 always looks up as scalar, even after a configuration write with a length of 2 or more.
- R9: When lk_valid_i is low, all three outputs are 0 on the next cycle.
- R10: At most one of bypass_o, vector_o and trap_o is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | IDX_W (5) | Register being configured |
| cfg_len_i | input | LEN_W (7) | Configured vector length |
| lk_valid_i | input | 1 | Lookup valid |
| rs1_use_i | input | 1 | First source is used |
| rs1_idx_i | input | IDX_W | First source index |
| rs2_use_i | input | 1 | Second source is used |
| rs2_idx_i | input | IDX_W | Second source index |
| rd_use_i | input | 1 | Destination is used |
| rd_idx_i | input | IDX_W | Destination index |
| trap_mode_i | input | 1 | 1: trap on a vector operand; 0: hardware vector path |
| bypass_o | output | 1 | Instruction is scalar-only |
| vector_o | output | 1 | Instruction goes to the vectorisation path |
| trap_o | output | 1 | Instruction must trap for emulation |

## Verification
Lookups are tried with the vectorised operand in each of the three slots in turn. This separates a wrong port wiring from a wrong AND. The same vectorised index is also presented with its use bit cleared, which exposes a missing operand mask. Same-cycle writes are tried both setting and clearing a flag, to catch a write-through path that is missing or inverted. A sweep configures alternating registers and then looks up every index, which catches per-entry decode errors, including at index 0 and index 31. A mid-run reset followed by lookups of the configured registers confirms that every flag was cleared.

// File: rtl/scalar_op_detect_pkg.sv
package scalar_op_detect_pkg;
  localparam int unsigned NUM_PORTS = 3;

  typedef struct packed {
    logic bypass;
    logic vector;
    logic trap;
  } route_t;
endpackage

// File: rtl/sod_len_decode.sv
module sod_len_decode #(
  parameter int unsigned LEN_W = 7
) (
  input  logic [LEN_W-1:0] len_i,
  output logic             vec_o
);
  // lengths 0 and 1 both mean scalar
  always_comb vec_o = (len_i > LEN_W'(1));
endmodule

// File: rtl/sod_bit_table.sv
module sod_bit_table #(
  parameter int unsigned NUM_REGS  = 32,
  parameter int unsigned NUM_PORTS = 3,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           we_i,
  input  logic [IDX_W-1:0]               widx_i,
  input  logic                           wbit_i,
  input  logic [NUM_PORTS-1:0][IDX_W-1:0] ridx_i,
  output logic [NUM_PORTS-1:0]           rbit_o
);
  logic [NUM_REGS-1:0] flag_q;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          flag_q[i] <= 1'b0;
      else if (we_i && widx_i == IDX_W'(i)) flag_q[i] <= wbit_i;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rport
    logic hit, raw;
    always_comb begin
      hit       = we_i && (widx_i == ridx_i[p]);
      raw       = hit ? wbit_i : flag_q[ridx_i[p]];
      // index 0 is hardwired scalar
      rbit_o[p] = raw && (ridx_i[p] != '0);
    end
  end
endmodule

// File: rtl/sod_classify.sv
module sod_classify
  import scalar_op_detect_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 3
) (
  input  logic                 valid_i,
  input  logic [NUM_PORTS-1:0] vec_bit_i,
  input  logic [NUM_PORTS-1:0] use_i,
  input  logic                 trap_mode_i,
  output route_t               route_o
);
  logic any_vec;
  always_comb begin
    any_vec        = |(vec_bit_i & use_i);
    route_o.bypass = valid_i && !any_vec;
    route_o.vector = valid_i && any_vec && !trap_mode_i;
    route_o.trap   = valid_i && any_vec &&  trap_mode_i;
  end
endmodule

// File: rtl/scalar_op_detect.sv
module scalar_op_detect
  import scalar_op_detect_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LEN_W    = 7,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [LEN_W-1:0] cfg_len_i,
  input  logic             lk_valid_i,
  input  logic             rs1_use_i,
  input  logic [IDX_W-1:0] rs1_idx_i,
  input  logic             rs2_use_i,
  input  logic [IDX_W-1:0] rs2_idx_i,
  input  logic             rd_use_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             trap_mode_i,
  output logic             bypass_o,
  output logic             vector_o,
  output logic             trap_o
);
  logic                            wbit;
  logic [NUM_PORTS-1:0][IDX_W-1:0] ridx;
  logic [NUM_PORTS-1:0]            use_v;
  logic [NUM_PORTS-1:0]            rbit;
  route_t                          route_d, route_q;

  assign ridx  = {rd_idx_i, rs2_idx_i, rs1_idx_i};
  assign use_v = {rd_use_i, rs2_use_i, rs1_use_i};

  sod_len_decode #(.LEN_W(LEN_W)) u_dec (
    .len_i (cfg_len_i),
    .vec_o (wbit)
  );

  sod_bit_table #(.NUM_REGS(NUM_REGS), .NUM_PORTS(NUM_PORTS)) u_tab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .widx_i (cfg_idx_i),
    .wbit_i (wbit),
    .ridx_i (ridx),
    .rbit_o (rbit)
  );

  sod_classify #(.NUM_PORTS(NUM_PORTS)) u_cls (
    .valid_i     (lk_valid_i),
    .vec_bit_i   (rbit),
    .use_i       (use_v),
    .trap_mode_i (trap_mode_i),
    .route_o     (route_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) route_q <= '0;
    else         route_q <= route_d;
  end

  assign bypass_o = route_q.bypass;
  assign vector_o = route_q.vector;
  assign trap_o   = route_q.trap;
endmodule

// File: rtl/scalar_op_detect_chk.sv
module scalar_op_detect_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned LEN_W    = 7,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_we_i,
  input logic [IDX_W-1:0] cfg_idx_i,
  input logic [LEN_W-1:0] cfg_len_i,
  input logic             lk_valid_i,
  input logic             rs1_use_i,
  input logic [IDX_W-1:0] rs1_idx_i,
  input logic             rs2_use_i,
  input logic [IDX_W-1:0] rs2_idx_i,
  input logic             rd_use_i,
  input logic [IDX_W-1:0] rd_idx_i,
  input logic             trap_mode_i,
  input logic             bypass_o,
  input logic             vector_o,
  input logic             trap_o
);
  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bypass_o, vector_o, trap_o}));

  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_valid_i |=> !bypass_o && !vector_o && !trap_o);

  p_hwmode_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && !trap_mode_i |=> !trap_o);

  p_trapmode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && trap_mode_i |=> !vector_o);

  p_unused_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && !rs1_use_i && !rs2_use_i && !rd_use_i |=> bypass_o);

  p_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && (!rs1_use_i || rs1_idx_i == '0) && (!rs2_use_i || rs2_idx_i == '0)
      && (!rd_use_i || rd_idx_i == '0) |=> bypass_o);

  p_wthru_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_valid_i && cfg_we_i && cfg_len_i > LEN_W'(1) && cfg_idx_i != '0
      && rs1_use_i && rs1_idx_i == cfg_idx_i |=> !bypass_o);
endmodule

bind scalar_op_detect scalar_op_detect_chk #(.NUM_REGS(NUM_REGS), .LEN_W(LEN_W)) u_chk (.*);

// File: tb/sim_scalar_op_detect.sv
`timescale 1ns/1ps
module sim_scalar_op_detect;
  localparam int NREG = 32;
  localparam int IW   = 5;
  localparam int LW   = 7;

  logic clk_i = 0, rst_ni = 0;
  logic cfg_we_i = 0, lk_valid_i = 0, trap_mode_i = 0;
  logic [IW-1:0] cfg_idx_i = '0, rs1_idx_i = '0, rs2_idx_i = '0, rd_idx_i = '0;
  logic [LW-1:0] cfg_len_i = '0;
  logic rs1_use_i = 0, rs2_use_i = 0, rd_use_i = 0;
  logic bypass_o, vector_o, trap_o;

  always #2 clk_i = ~clk_i;

  scalar_op_detect u0 (.*);

  typedef struct { logic [2:0] exp; string req; } item_t;
  item_t q[$];
  int checks = 0, fails = 0;
  logic model[NREG];

  task automatic chk(input logic [2:0] act, input logic [2:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%b exp=%b (bypass,vector,trap)", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, queue expected result
  task automatic drive(input logic we, input int widx, input int len,
                       input logic v, input logic tm,
                       input logic u1, input int i1, input logic u2, input int i2,
                       input logic ud, input int id, input string req);
    item_t it;
    logic anyv;
    @(negedge clk_i);
    cfg_we_i = we; cfg_idx_i = IW'(widx); cfg_len_i = LW'(len);
    lk_valid_i = v; trap_mode_i = tm;
    rs1_use_i = u1; rs1_idx_i = IW'(i1);
    rs2_use_i = u2; rs2_idx_i = IW'(i2);
    rd_use_i = ud; rd_idx_i = IW'(id);
    if (we) model[widx] = (len >= 2);
    anyv = (u1 && i1 != 0 && model[i1]) || (u2 && i2 != 0 && model[i2]) ||
           (ud && id != 0 && model[id]);
    it.exp = {v && !anyv, v && anyv && !tm, v && anyv && tm};
    it.req = req;
    @(posedge clk_i);
    q.push_back(it);
  endtask

  task automatic idle(input string req);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk({bypass_o, vector_o, trap_o}, it.exp, it.req);
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) model[i] = 0;
    repeat (3) @(negedge clk_i);
    chk({bypass_o, vector_o, trap_o}, 3'b000, "R1 outputs in reset");
    rst_ni = 1;
    idle("R9 idle after reset");
    drive(0, 0, 0, 1, 0, 1, 5, 1, 6, 1, 31, "R1 unconfigured regs scalar");
    drive(1, 5, 4, 0, 0, 0, 0, 0, 0, 0, 0, "R9 write only");
    drive(0, 0, 0, 1, 0, 1, 5, 1, 1, 1, 2, "R2 R4 rs1 vectorised");
    drive(0, 0, 0, 1, 0, 1, 1, 1, 5, 1, 2, "R4 rs2 vectorised");
    drive(0, 0, 0, 1, 0, 1, 1, 1, 2, 1, 5, "R3 R4 rd vectorised");
    drive(0, 0, 0, 1, 1, 1, 5, 1, 1, 1, 2, "R5 trap mode");
    drive(0, 0, 0, 1, 1, 1, 1, 1, 2, 1, 3, "R5 trap mode scalar bypass");
    drive(0, 0, 0, 1, 0, 0, 5, 0, 5, 1, 3, "R6 unused ports masked");
    drive(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R6 no operands");
    drive(1, 9, 2, 1, 0, 0, 0, 0, 0, 1, 9, "R7 same-cycle set");
    drive(1, 9, 1, 1, 0, 0, 0, 0, 0, 1, 9, "R7 same-cycle clear");
    drive(1, 5, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 clear write");
    drive(0, 0, 0, 1, 0, 1, 5, 0, 0, 0, 0, "R2 len 1 scalar");
    drive(1, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 len 0 write");
    drive(0, 0, 0, 1, 0, 1, 6, 0, 0, 0, 0, "R2 len 0 scalar");
    drive(1, 0, 8, 1, 0, 1, 0, 1, 0, 1, 0, "R8 x0 write-through");
    drive(0, 0, 0, 1, 1, 1, 0, 1, 0, 1, 0, "R8 x0 stays scalar");
    drive(1, 7, 127, 0, 0, 0, 0, 0, 0, 0, 0, "R2 max len write");
    drive(0, 0, 0, 1, 0, 0, 0, 1, 7, 0, 0, "R2 max len vectorised");
    for (int i = 0; i < NREG; i++)
      drive(1, i, (i % 2) ? 3 : 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 sweep write");
    for (int i = 0; i < NREG; i++)
      drive(0, 0, 0, 1, i % 3 == 0, 1, i, 0, 0, 1, 2, "R3 sweep lookup");
    idle("R9 idle");
    idle("R9 idle");
    wait (q.size() == 0);
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    chk({bypass_o, vector_o, trap_o}, 3'b000, "R1 outputs during reset");
    for (int i = 0; i < NREG; i++) model[i] = 0;
    @(negedge clk_i);
    rst_ni = 1;
    for (int i = 1; i < NREG; i += 2)
      drive(0, 0, 0, 1, 0, 0, 0, 1, i, 0, 0, "R1 flags cleared by reset");
    idle("R9 drain");
    wait (q.size() == 0);
    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule